// File: doc/BRIEF.md
# Passive-Parallel Configuration Sequencer

This block walks a target FPGA through one complete passive-parallel programming cycle. It owns the configuration control pins: nCONFIG, chip enable (nCE) and the active-low override enables. It watches the pin levels sensed back from the target. A single `start_i` pulse begins a run. The block first checks the mode-select straps. It then confirms that nothing else is driving the configuration pins, takes over those pins and pulses nCONFIG with an nSTATUS handshake. After a sanity check on CONF_DONE, it opens the clock and data path.

The bitstream words are streamed by a separate engine. That engine sees `data_en_o` and answers with a one-cycle `data_done_i` when the last word has gone out. The sequencer then polls CONF_DONE and requests a fixed burst of extra configuration clocks. It waits for user mode, then hands the pins back in a set order. A final three-signal check decides between `done_o` and an error code.

Every sensed pin passes through a synchroniser before the state machine uses it. Every wait is bounded by a cycle-count parameter. All control inputs are single-cycle, synchronous pulses.

Top module: `ppcfg_seq`

## Requirements
- R1: After reset, and whenever no run is active, the block leaves all pins released: `ncfg_drv_o`=1, `nce_o`=1, all four `*_ovr_n_o`=1, `clk_en_o`=`data_en_o`=`dclk_req_o`=0, `busy_o`=0. `done_o`=0, `err_o`=0 and `ratio_o`=0 out of reset.
- R2: When `start_i` arrives while idle, the synchronised `msel_i` is checked. If bit 1 or bit 2 is set, no pin moves and `err_o` becomes 1 (mode error). If only bit 0 or no bit is set, the run begins with `busy_o`=1.
- R3: The block waits until the sensed nCONFIG and nSTATUS both read low, once before taking the pins and once more after nCE goes low. If WAIT_CYC cycles pass in either wait, the run aborts with `err_o`=2 (timeout).
- R4: After the first pre-wait, `cfg_ovr_n_o` and `ncfg_ovr_n_o` go low while `nstat_ovr_n_o` and `cdone_ovr_n_o` stay high. In a later cycle, `nce_o` goes low.
- R5: Reset handshake: `ncfg_drv_o` is held low until the sensed nSTATUS reads low. It is then held high until the sensed nSTATUS reads high. Each wait is bounded by WAIT_CYC cycles and aborts with `err_o`=2.
- R6: After the handshake, if the sensed CONF_DONE is low and the sensed CONF_DONE output-enable is high, `clk_en_o` and `data_en_o` rise together. Otherwise the run aborts with `err_o`=3 (reset-check error).
- R7: The data path stays open until `data_done_i` pulses. The block then polls the sensed CONF_DONE. A sensed nSTATUS low during this poll aborts with `err_o`=4. If CONF_DONE does not rise within CD_CYC cycles, the run aborts with `err_o`=2. When both conditions are present in the same cycle, a high CONF_DONE wins.
- R8: Once CONF_DONE is high, `dclk_req_o` is high for exactly EXTRA_DCLK consecutive cycles (default 15). The block then waits for the sensed user-mode flag. If UM_CYC cycles pass first, the run aborts with `err_o`=2.
- R9: After user mode is reached, the pins are released in three steps on separate cycles. First `clk_en_o`/`data_en_o` fall. Next both override enables return high. Last `nce_o` returns high.
- R10: Final check: the run ends with `done_o`=1 and `err_o`=0 only if the sensed user mode, CONF_DONE and nSTATUS all read high. Otherwise it ends with `err_o`=5 (final-check error).
- R11: Any abort returns every output to the released state of R1 in the same cycle and drops `busy_o`. `done_o` and `err_o` hold their result until the next accepted `start_i`.
- R12: A `start_i` pulse during a run has no effect on the pin sequence or on `ratio_o`.
- R13: `ratio_i` is captured into `ratio_o` when a run is accepted and is held there until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a configuration run |
| data_done_i | input | 1 | One-cycle pulse: bitstream streaming finished |
| ratio_i | input | RW | Chosen clock-to-data ratio code |
| msel_i | input | 3 | Sensed mode-select straps |
| ncfg_sense_i | input | 1 | Sensed nCONFIG pin level |
| nstat_sense_i | input | 1 | Sensed nSTATUS pin level |
| cdone_sense_i | input | 1 | Sensed CONF_DONE pin level |
| cdone_oe_sense_i | input | 1 | Sensed CONF_DONE output-enable indication |
| umode_sense_i | input | 1 | Sensed user-mode indication |
| ncfg_drv_o | output | 1 | Driven nCONFIG level |
| nce_o | output | 1 | Driven chip enable, active low |
| cfg_ovr_n_o | output | 1 | Active-low override enable for the config pins |
| ncfg_ovr_n_o | output | 1 | Active-low override enable for nCONFIG |
| nstat_ovr_n_o | output | 1 | Active-low drive enable for nSTATUS (kept off) |
| cdone_ovr_n_o | output | 1 | Active-low drive enable for CONF_DONE (kept off) |
| clk_en_o | output | 1 | Configuration clock enable |
| data_en_o | output | 1 | Data-path enable that gates the streaming engine |
| dclk_req_o | output | 1 | Extra configuration-clock burst request |
| ratio_o | output | RW | Ratio code latched for the active run |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | Last run succeeded |
| err_o | output | 3 | Last run's error code (0 none, 1 mode, 2 timeout, 3 reset check, 4 nSTATUS drop, 5 final check) |

## Verification
The assertions assume that `start_i` and `data_done_i` are synchronous, single-cycle pulses. They also assume that sensed pins are sampled only after the two-stage synchroniser, so a pin change reaches the state machine two cycles late. The bench changes sensed pins and control pulses only on falling clock edges. It sets the mode straps several cycles before each start, so the synchronised copy has settled. The bench reacts to the driven nCONFIG level the way a target would, raising nSTATUS only after the reset pulse ends. This keeps every handshake inside the shortened timeout windows, except where a scenario deliberately withholds a response.

// File: rtl/ppcfg_pkg.sv
package ppcfg_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PRE1, ST_OVR, ST_NCE, ST_PRE2, ST_RLO, ST_RHI, ST_RCHK,
    ST_DATA, ST_CDW, ST_DCLK, ST_UMW, ST_REL1, ST_REL2, ST_REL3, ST_FIN
  } state_t;

  localparam logic [2:0] ERR_NONE  = 3'd0;
  localparam logic [2:0] ERR_MODE  = 3'd1;
  localparam logic [2:0] ERR_TMO   = 3'd2;
  localparam logic [2:0] ERR_RCHK  = 3'd3;
  localparam logic [2:0] ERR_NSTAT = 3'd4;
  localparam logic [2:0] ERR_FINAL = 3'd5;

  typedef struct packed {
    logic ncfg;
    logic nce;
    logic cfg_ovr_n;
    logic ncfg_ovr_n;
    logic nstat_ovr_n;
    logic cdone_ovr_n;
    logic clk_en;
    logic data_en;
    logic dclk_req;
    logic busy;
  } drv_t;

endpackage

// File: rtl/ppcfg_sync.sv
module ppcfg_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  generate
    if (STAGES < 2) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg <= '0;
        else        stg <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg <= '0;
        else        stg <= {stg[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/ppcfg_timer.sv
module ppcfg_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic [CW-1:0] limit,
  output logic          hit
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (en)  cnt <= cnt + CW'(1);
  end

  assign hit = en && (cnt == limit - CW'(1));

  // R3: a timed wait never runs past its own window
  p_cnt_below_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt < limit));
endmodule

// File: rtl/ppcfg_drive_dec.sv
module ppcfg_drive_dec
  import ppcfg_pkg::*;
(
  input  state_t st,
  output drv_t   drv
);
  always_comb begin
    drv             = '0;
    drv.ncfg        = 1'b1;
    drv.nce         = 1'b1;
    drv.cfg_ovr_n   = 1'b1;
    drv.ncfg_ovr_n  = 1'b1;
    drv.nstat_ovr_n = 1'b1;
    drv.cdone_ovr_n = 1'b1;
    drv.busy        = (st != ST_IDLE);
    case (st)
      ST_OVR: begin
        drv.cfg_ovr_n  = 1'b0;
        drv.ncfg_ovr_n = 1'b0;
      end
      ST_NCE, ST_PRE2, ST_RHI, ST_RCHK, ST_REL1: begin
        drv.cfg_ovr_n  = 1'b0;
        drv.ncfg_ovr_n = 1'b0;
        drv.nce        = 1'b0;
      end
      ST_RLO: begin
        drv.cfg_ovr_n  = 1'b0;
        drv.ncfg_ovr_n = 1'b0;
        drv.nce        = 1'b0;
        drv.ncfg       = 1'b0;
      end
      ST_DATA, ST_CDW, ST_DCLK, ST_UMW: begin
        drv.cfg_ovr_n  = 1'b0;
        drv.ncfg_ovr_n = 1'b0;
        drv.nce        = 1'b0;
        drv.clk_en     = 1'b1;
        drv.data_en    = 1'b1;
        drv.dclk_req   = (st == ST_DCLK);
      end
      ST_REL2: drv.nce = 1'b0;
      default: ;
    endcase
  end
endmodule

// File: rtl/ppcfg_seq.sv
module ppcfg_seq
  import ppcfg_pkg::*;
#(
  parameter int RW         = 2,
  parameter int WAIT_CYC   = 1000,
  parameter int CD_CYC     = 32'h0100_0000,
  parameter int UM_CYC     = 1000,
  parameter int EXTRA_DCLK = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          data_done_i,
  input  logic [RW-1:0] ratio_i,
  input  logic [2:0]    msel_i,
  input  logic          ncfg_sense_i,
  input  logic          nstat_sense_i,
  input  logic          cdone_sense_i,
  input  logic          cdone_oe_sense_i,
  input  logic          umode_sense_i,
  output logic          ncfg_drv_o,
  output logic          nce_o,
  output logic          cfg_ovr_n_o,
  output logic          ncfg_ovr_n_o,
  output logic          nstat_ovr_n_o,
  output logic          cdone_ovr_n_o,
  output logic          clk_en_o,
  output logic          data_en_o,
  output logic          dclk_req_o,
  output logic [RW-1:0] ratio_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [2:0]    err_o
);
  localparam int M1   = (WAIT_CYC > CD_CYC) ? WAIT_CYC : CD_CYC;
  localparam int M2   = (UM_CYC > EXTRA_DCLK) ? UM_CYC : EXTRA_DCLK;
  localparam int MAXL = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(MAXL + 1);
  localparam int SW   = 8;

  // synchronised sensed pins
  logic [SW-1:0] raw_s, syn_s;
  logic [2:0]    msel_s;
  logic          ncfg_s, nstat_s, cdone_s, cdoe_s, umode_s;

  assign raw_s = {msel_i, ncfg_sense_i, nstat_sense_i, cdone_sense_i,
                  cdone_oe_sense_i, umode_sense_i};

  ppcfg_sync #(.W(SW), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_s), .q(syn_s));

  assign {msel_s, ncfg_s, nstat_s, cdone_s, cdoe_s, umode_s} = syn_s;

  state_t          st_q, st_n;
  logic [2:0]      err_q, err_n;
  logic            done_q, done_n;
  logic [RW-1:0]   ratio_q, ratio_n;
  logic            tm_en, tm_hit;
  logic [CW-1:0]   tm_lim;
  drv_t            drv;

  always_comb begin
    tm_en  = 1'b1;
    tm_lim = CW'(WAIT_CYC);
    case (st_q)
      ST_PRE1, ST_PRE2, ST_RLO, ST_RHI: tm_lim = CW'(WAIT_CYC);
      ST_CDW:  tm_lim = CW'(CD_CYC);
      ST_DCLK: tm_lim = CW'(EXTRA_DCLK);
      ST_UMW:  tm_lim = CW'(UM_CYC);
      default: tm_en  = 1'b0;
    endcase
  end

  ppcfg_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(st_n != st_q), .en(tm_en),
    .limit(tm_lim), .hit(tm_hit));

  always_comb begin
    st_n    = st_q;
    err_n   = err_q;
    done_n  = done_q;
    ratio_n = ratio_q;
    case (st_q)
      ST_IDLE: if (start_i) begin
        done_n = 1'b0;
        if ((msel_s & 3'b110) != 3'b000) begin
          err_n = ERR_MODE;
        end else begin
          err_n   = ERR_NONE;
          ratio_n = ratio_i;
          st_n    = ST_PRE1;
        end
      end
      ST_PRE1, ST_PRE2: begin
        if (!ncfg_s && !nstat_s) st_n = (st_q == ST_PRE1) ? ST_OVR : ST_RLO;
        else if (tm_hit) begin st_n = ST_IDLE; err_n = ERR_TMO; end
      end
      ST_OVR: st_n = ST_NCE;
      ST_NCE: st_n = ST_PRE2;
      ST_RLO: begin
        if (!nstat_s)    st_n = ST_RHI;
        else if (tm_hit) begin st_n = ST_IDLE; err_n = ERR_TMO; end
      end
      ST_RHI: begin
        if (nstat_s)     st_n = ST_RCHK;
        else if (tm_hit) begin st_n = ST_IDLE; err_n = ERR_TMO; end
      end
      ST_RCHK: begin
        if (!cdone_s && cdoe_s) st_n = ST_DATA;
        else begin st_n = ST_IDLE; err_n = ERR_RCHK; end
      end
      ST_DATA: if (data_done_i) st_n = ST_CDW;
      ST_CDW: begin
        if (cdone_s)      st_n = ST_DCLK;
        else if (!nstat_s) begin st_n = ST_IDLE; err_n = ERR_NSTAT; end
        else if (tm_hit)  begin st_n = ST_IDLE; err_n = ERR_TMO; end
      end
      ST_DCLK: if (tm_hit) st_n = ST_UMW;
      ST_UMW: begin
        if (umode_s)     st_n = ST_REL1;
        else if (tm_hit) begin st_n = ST_IDLE; err_n = ERR_TMO; end
      end
      ST_REL1: st_n = ST_REL2;
      ST_REL2: st_n = ST_REL3;
      ST_REL3: st_n = ST_FIN;
      ST_FIN: begin
        st_n = ST_IDLE;
        if (umode_s && cdone_s && nstat_s) done_n = 1'b1;
        else                               err_n  = ERR_FINAL;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      err_q   <= ERR_NONE;
      done_q  <= 1'b0;
      ratio_q <= '0;
    end else begin
      st_q    <= st_n;
      err_q   <= err_n;
      done_q  <= done_n;
      ratio_q <= ratio_n;
    end
  end

  ppcfg_drive_dec u_dec (.st(st_q), .drv(drv));

  assign ncfg_drv_o    = drv.ncfg;
  assign nce_o         = drv.nce;
  assign cfg_ovr_n_o   = drv.cfg_ovr_n;
  assign ncfg_ovr_n_o  = drv.ncfg_ovr_n;
  assign nstat_ovr_n_o = drv.nstat_ovr_n;
  assign cdone_ovr_n_o = drv.cdone_ovr_n;
  assign clk_en_o      = drv.clk_en;
  assign data_en_o     = drv.data_en;
  assign dclk_req_o    = drv.dclk_req;
  assign busy_o        = drv.busy;
  assign ratio_o       = ratio_q;
  assign done_o        = done_q;
  assign err_o         = err_q;

  // R11: chip enable is only driven while a run is active
  p_nce_only_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !nce_o |-> busy_o);
  // R6: data path opens only with overrides on and chip enabled
  p_data_needs_ovr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    data_en_o |-> (!cfg_ovr_n_o && !nce_o && clk_en_o));
  // R8: burst request only while the clock path is enabled
  p_dclk_with_clk_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dclk_req_o |-> clk_en_o);
  // R5: the nCONFIG pulse starts only after chip enable is low
  p_pulse_after_nce_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ncfg_drv_o) |-> !nce_o);
  // R10: success carries no error and no activity
  p_done_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (err_o == ERR_NONE && !busy_o));
  // R13: ratio stays fixed for the whole run
  p_ratio_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(ratio_o));
endmodule

// File: tb/ppcfg_seq_bench.sv
module ppcfg_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WAITC = 20, CDC = 40, UMC = 40, XDCLK = 15;

  // vector order: ncfg nce cfgovr ncfgovr nstovr cdovr clk dat dclk busy done err[2:0]
  localparam logic [13:0] V_PRE = 14'b1_1_1_1_1_1_0_0_0_1_0_000;
  localparam logic [13:0] V_OVR = 14'b1_1_0_0_1_1_0_0_0_1_0_000;
  localparam logic [13:0] V_NCE = 14'b1_0_0_0_1_1_0_0_0_1_0_000;
  localparam logic [13:0] V_RLO = 14'b0_0_0_0_1_1_0_0_0_1_0_000;
  localparam logic [13:0] V_DAT = 14'b1_0_0_0_1_1_1_1_0_1_0_000;
  localparam logic [13:0] V_DCK = 14'b1_0_0_0_1_1_1_1_1_1_0_000;
  localparam logic [13:0] V_RL2 = 14'b1_0_1_1_1_1_0_0_0_1_0_000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, ddone = 1'b0;
  logic [1:0] ratio = 2'd1;
  logic [2:0] msel = 3'b001;
  logic s_ncfg = 1'b0, s_nst = 1'b0, s_cd = 1'b0, s_cdoe = 1'b1, s_um = 1'b0;
  logic ncfg_drv_o, nce_o, cfg_ovr_n_o, ncfg_ovr_n_o, nstat_ovr_n_o, cdone_ovr_n_o;
  logic clk_en_o, data_en_o, dclk_req_o, busy_o, done_o;
  logic [1:0] ratio_o;
  logic [2:0] err_o;

  int checks = 0, errors = 0;
  bit finished = 0, mon_on = 0;
  logic [13:0] exp_q[$];
  logic [13:0] cur, prev;

  always #(CLK_PERIOD/2) clk = ~clk;

  ppcfg_seq #(.RW(2), .WAIT_CYC(WAITC), .CD_CYC(CDC), .UM_CYC(UMC),
              .EXTRA_DCLK(XDCLK)) u_ppcfg_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .data_done_i(ddone),
    .ratio_i(ratio), .msel_i(msel), .ncfg_sense_i(s_ncfg),
    .nstat_sense_i(s_nst), .cdone_sense_i(s_cd), .cdone_oe_sense_i(s_cdoe),
    .umode_sense_i(s_um), .ncfg_drv_o(ncfg_drv_o), .nce_o(nce_o),
    .cfg_ovr_n_o(cfg_ovr_n_o), .ncfg_ovr_n_o(ncfg_ovr_n_o),
    .nstat_ovr_n_o(nstat_ovr_n_o), .cdone_ovr_n_o(cdone_ovr_n_o),
    .clk_en_o(clk_en_o), .data_en_o(data_en_o), .dclk_req_o(dclk_req_o),
    .ratio_o(ratio_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o));

  function automatic logic [13:0] v_idle(input logic d, input logic [2:0] e);
    return {10'b1111110000, d, e};
  endfunction

  function automatic logic [13:0] outv();
    return {ncfg_drv_o, nce_o, cfg_ovr_n_o, ncfg_ovr_n_o, nstat_ovr_n_o,
            cdone_ovr_n_o, clk_en_o, data_en_o, dclk_req_o, busy_o, done_o, err_o};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // monitor: each change of the output vector pops one expected item
  always @(negedge clk) begin
    if (mon_on) begin
      cur = outv();
      if (cur != prev) begin
        if (exp_q.size() == 0) chk(0, "R11 unexpected output change", int'(cur), 0);
        else begin
          logic [13:0] e;
          e = exp_q.pop_front();
          chk(cur == e, "R4/R5/R9 output sequence", int'(cur), int'(e));
        end
        prev = cur;
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start();
    start = 1'b1; cyc(1); start = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy_o) cyc(1);
    cyc(3);
  endtask

  task automatic drained(input string req);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  task automatic push_reset_seq();
    exp_q.push_back(V_PRE); exp_q.push_back(V_OVR); exp_q.push_back(V_NCE);
    exp_q.push_back(V_RLO); exp_q.push_back(V_NCE);
  endtask

  // drive a run through the nCONFIG pulse; raise nSTATUS after it if asked
  task automatic run_reset(input logic cdoe, input bit raise);
    s_ncfg = 0; s_nst = 0; s_cd = 0; s_cdoe = cdoe; s_um = 0; msel = 3'b001;
    cyc(4);
    pulse_start();
    while (ncfg_drv_o !== 1'b0) cyc(1);
    while (ncfg_drv_o !== 1'b1) cyc(1);
    if (raise) s_nst = 1'b1;
  endtask

  task automatic reach_data();
    run_reset(1'b1, 1'b1);
    while (data_en_o !== 1'b1) cyc(1);
    cyc(3);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1: released state after reset
    chk(outv() == v_idle(1'b0, 3'd0), "R1 reset outputs", int'(outv()), int'(v_idle(1'b0, 3'd0)));
    chk(ratio_o == 2'd0, "R1 reset ratio", ratio_o, 0);
    prev = outv();
    mon_on = 1;

    // A: full successful run, msel bit0 set (R2, R3, R4, R6, R7, R8, R9, R10, R12, R13)
    push_reset_seq();
    exp_q.push_back(V_DAT); exp_q.push_back(V_DCK); exp_q.push_back(V_DAT);
    exp_q.push_back(V_NCE); exp_q.push_back(V_RL2); exp_q.push_back(V_PRE);
    exp_q.push_back(v_idle(1'b1, 3'd0));
    ratio = 2'd1;
    reach_data();
    ratio = 2'd3; pulse_start();          // R12: ignored while busy
    cyc(2);
    ddone = 1'b1; cyc(1); ddone = 1'b0;
    cyc(5); s_cd = 1'b1;
    while (dclk_req_o !== 1'b1) cyc(1);
    begin
      int n = 0;
      while (dclk_req_o === 1'b1) begin n++; cyc(1); end
      chk(n == XDCLK, "R8 burst length", n, XDCLK);
    end
    s_um = 1'b1;
    wait_idle();
    chk(ratio_o == 2'd1, "R13 ratio latched at start (R12)", ratio_o, 1);
    chk(done_o == 1'b1 && err_o == 3'd0, "R10 success", {done_o, err_o}, 8);
    drained("R9 sequence complete");

    // B: mode error, no pin moves (R2)
    exp_q.push_back(v_idle(1'b0, 3'd1));
    msel = 3'b010; ratio = 2'd2; cyc(4);
    pulse_start(); cyc(10);
    chk(ratio_o == 2'd1, "R2 ratio untouched on mode error", ratio_o, 1);
    drained("R2 mode error");
    msel = 3'b100; cyc(4); pulse_start(); cyc(10);
    chk(err_o == 3'd1 && !busy_o, "R2 bit2 mode error", err_o, 1);

    // C: pre-wait timeout, nSTATUS stuck high (R3, R11)
    exp_q.push_back(V_PRE); exp_q.push_back(v_idle(1'b0, 3'd2));
    s_nst = 1'b1; msel = 3'b000; cyc(4);
    pulse_start(); cyc(WAITC + 10);
    drained("R3 pre-wait timeout");

    // D: reset check fails, CONF_DONE oe low (R6)
    push_reset_seq(); exp_q.push_back(v_idle(1'b0, 3'd3));
    run_reset(1'b0, 1'b1);
    wait_idle();
    drained("R6 reset-check error");

    // J: nSTATUS never returns high (R5)
    push_reset_seq(); exp_q.push_back(v_idle(1'b0, 3'd2));
    run_reset(1'b1, 1'b0);
    wait_idle();
    drained("R5 handshake timeout");

    // E: nSTATUS drops while polling CONF_DONE (R7)
    push_reset_seq(); exp_q.push_back(V_DAT); exp_q.push_back(v_idle(1'b0, 3'd4));
    reach_data();
    ddone = 1'b1; cyc(1); ddone = 1'b0; s_nst = 1'b0;
    wait_idle();
    drained("R7 nSTATUS drop");

    // F: CONF_DONE never rises (R7)
    push_reset_seq(); exp_q.push_back(V_DAT); exp_q.push_back(v_idle(1'b0, 3'd2));
    reach_data();
    cyc(8);
    chk(data_en_o == 1'b1, "R7 data path held until data_done", data_en_o, 1);
    ddone = 1'b1; cyc(1); ddone = 1'b0;
    wait_idle();
    drained("R7 CONF_DONE timeout");

    // G: user mode never reached (R8)
    push_reset_seq(); exp_q.push_back(V_DAT); exp_q.push_back(V_DCK);
    exp_q.push_back(V_DAT); exp_q.push_back(v_idle(1'b0, 3'd2));
    reach_data();
    ddone = 1'b1; cyc(1); ddone = 1'b0; s_cd = 1'b1;
    wait_idle();
    drained("R8 user-mode timeout");

    // H: CONF_DONE low at final check (R10)
    push_reset_seq(); exp_q.push_back(V_DAT); exp_q.push_back(V_DCK);
    exp_q.push_back(V_DAT); exp_q.push_back(V_NCE); exp_q.push_back(V_RL2);
    exp_q.push_back(V_PRE); exp_q.push_back(v_idle(1'b0, 3'd5));
    reach_data();
    ddone = 1'b1; cyc(1); ddone = 1'b0; s_cd = 1'b1;
    while (dclk_req_o !== 1'b1) cyc(1);
    while (dclk_req_o === 1'b1) cyc(1);
    s_um = 1'b1; s_cd = 1'b0;
    wait_idle();
    drained("R10 final-check error");

    mon_on = 0;
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule